// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

The block receives asynchronous serial characters made of one start bit, eight data bits sent least significant bit first, and one stop bit. A 16x oversample tick from outside drives all of its timing. The line passes through a two-flop synchronizer. The receiver then finds a start bit, takes three votes near the centre of every bit and moves each completed character into a parallel receive data register. Software reads that register through the data read strobe.

Five status flags go with the register: receive-full, overrun, noise, framing error and idle. If a character completes while the register still holds an unread one, the new character is discarded. The register keeps its old contents and the overrun flag is raised. The idle flag marks the point where the line returns to rest after activity. Receive-full, overrun and idle can request an interrupt through two enables. Noise and framing error are informational only.

Top module: `uart_rx_status`

## Requirements
- R1: A start bit is accepted only after a high-to-low transition on the synchronized line that is still low at the mid-bit vote. A low pulse that has ended by mid-bit starts no character.
- R2: Each bit's value is the majority of three samples taken on oversample ticks 7, 8 and 9 of the bit. Data bits arrive least significant bit first and are assembled into data_o[7:0].
- R3: When a character completes and the data register is empty, the byte is loaded into data_o and full_o is set.
- R4: When a character completes while full_o is still set, the byte is dropped, data_o is unchanged and ovr_o is set. full_o stays set.
- R5: noise_o is set for the held character when the three votes of any of its bits (start, data or stop) disagree. The majority value is still used for that bit.
- R6: ferr_o is set for the held character when the voted stop bit is 0.
- R7: idle_o is set once the line has been high for 160 oversample ticks (ten bit times) after having been low. A line that has stayed high since reset, or since the last idle event, does not set it.
- R8: A data read strobe clears full_o, ovr_o, noise_o, ferr_o and idle_o only if a status read strobe came earlier. A data read with no earlier status read changes no flag.
- R9: irq_o is high exactly when (rx_ie_i and (full_o or ovr_o)) or (idle_ie_i and idle_o).
- R10: After reset, data_o is 0 and all flags and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, asynchronous |
| tick_i | input | 1 | Oversample enable, 16 per bit |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| rx_ie_i | input | 1 | Interrupt enable for full and overrun |
| idle_ie_i | input | 1 | Interrupt enable for idle |
| data_o | output | 8 | Receive data register |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag of the held character |
| ferr_o | output | 1 | Framing error flag of the held character |
| idle_o | output | 1 | Idle-line flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A slip in the sub-bit counter or the bit counter moves the vote point or the bit boundary. That shows up at the end of the same frame as a wrong byte, a spurious noise flag or a false framing error. A stuck clear-sequence latch shows on the next data read, as flags that clear too early or never clear. An overrun decision based on the wrong fullness would overwrite data_o with the second byte and be visible as soon as that frame ends. A broken idle arming shows either as idle on a line that was never active, or as a second idle event on a line that stayed high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 noise_o,
  output logic                 ferr_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [SUB_W-1:0] S_A   = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] S_B   = SUB_W'(OVS / 2);
  localparam logic [SUB_W-1:0] S_C   = SUB_W'(OVS / 2 + 1);
  localparam logic [SUB_W-1:0] S_END = SUB_W'(OVS - 1);
  localparam logic [CNT_W-1:0] N_BITS = CNT_W'(DATA_BITS);

  rx_state_e             state_q;
  logic [SUB_W-1:0]      sub_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [DATA_BITS-1:0]  shift_q;
  logic                  s_a_q, s_b_q, noise_acc_q, last_hi_q;
  logic                  vote, split;

  assign vote   = maj3(s_a_q, s_b_q, line_i);
  assign split  = (s_a_q != s_b_q) || (s_b_q != line_i);
  assign byte_o = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      sub_q       <= '0;
      cnt_q       <= '0;
      shift_q     <= '0;
      s_a_q       <= 1'b1;
      s_b_q       <= 1'b1;
      noise_acc_q <= 1'b0;
      last_hi_q   <= 1'b0;
      done_o      <= 1'b0;
      noise_o     <= 1'b0;
      ferr_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (state_q == RX_IDLE) begin
          last_hi_q <= line_i;
          if (last_hi_q && !line_i) begin
            state_q     <= RX_START;
            sub_q       <= SUB_W'(1);  // edge tick is sub-bit 0
            noise_acc_q <= 1'b0;
            cnt_q       <= '0;
          end
        end else begin
          sub_q <= (sub_q == S_END) ? '0 : sub_q + 1'b1;
          if (sub_q == S_A) s_a_q <= line_i;
          if (sub_q == S_B) s_b_q <= line_i;
          if (sub_q == S_C) begin
            unique case (state_q)
              RX_START: begin
                if (vote) begin
                  state_q   <= RX_IDLE;  // false start
                  last_hi_q <= 1'b1;
                end else begin
                  noise_acc_q <= split;
                end
              end
              RX_DATA: begin
                shift_q     <= {vote, shift_q[DATA_BITS-1:1]};
                noise_acc_q <= noise_acc_q | split;
                cnt_q       <= cnt_q + 1'b1;
              end
              RX_STOP: begin
                done_o    <= 1'b1;
                noise_o   <= noise_acc_q | split;
                ferr_o    <= !vote;
                last_hi_q <= vote;
                state_q   <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (sub_q == S_END) begin
            if (state_q == RX_START) state_q <= RX_DATA;
            else if (state_q == RX_DATA && cnt_q == N_BITS) state_q <= RX_STOP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic idle_set_o
);
  localparam int LIMIT = OVS * IDLE_BITS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] hi_cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q   <= '0;
      armed_q    <= 1'b0;
      idle_set_o <= 1'b0;
    end else begin
      idle_set_o <= 1'b0;
      if (tick_i) begin
        if (!line_i) begin
          hi_cnt_q <= '0;
          armed_q  <= 1'b1;
        end else if (armed_q) begin
          if (hi_cnt_q == LAST) begin
            idle_set_o <= 1'b1;
            armed_q    <= 1'b0;
            hi_cnt_q   <= '0;
          end else begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 noise_i,
  input  logic                 ferr_i,
  input  logic                 idle_set_i,
  input  logic                 stat_rd_i,
  input  logic                 data_rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o,
  output logic                 ovr_o,
  output logic                 noise_o,
  output logic                 ferr_o,
  output logic                 idle_o
);
  logic stat_seen_q, clr, full_left;

  assign clr       = data_rd_i && stat_seen_q;
  assign full_left = full_o && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_seen_q <= 1'b0;
      data_o      <= '0;
      full_o      <= 1'b0;
      ovr_o       <= 1'b0;
      noise_o     <= 1'b0;
      ferr_o      <= 1'b0;
      idle_o      <= 1'b0;
    end else begin
      if (data_rd_i)      stat_seen_q <= 1'b0;
      else if (stat_rd_i) stat_seen_q <= 1'b1;

      full_o  <= full_left;
      ovr_o   <= ovr_o && !clr;
      noise_o <= noise_o && !clr;
      ferr_o  <= ferr_o && !clr;
      idle_o  <= (idle_o && !clr) || idle_set_i;

      if (done_i) begin
        if (full_left) begin
          ovr_o <= 1'b1;  // new byte dropped, held byte kept
        end else begin
          data_o  <= byte_i;
          full_o  <= 1'b1;
          noise_o <= noise_i;
          ferr_o  <= ferr_i;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rxd_i,
  input  logic                 tick_i,
  input  logic                 stat_rd_i,
  input  logic                 data_rd_i,
  input  logic                 rx_ie_i,
  input  logic                 idle_ie_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o,
  output logic                 ovr_o,
  output logic                 noise_o,
  output logic                 ferr_o,
  output logic                 idle_o,
  output logic                 irq_o
);
  logic [1:0]           sync_q;
  logic                 line;
  logic                 done;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 rx_noise, rx_ferr, idle_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign line = sync_q[1];

  uart_rx_sampler #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .line_i (line),
    .done_o (done),
    .byte_o (rx_byte),
    .noise_o(rx_noise),
    .ferr_o (rx_ferr)
  );

  uart_rx_idle #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line),
    .idle_set_o(idle_set)
  );

  uart_rx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .byte_i    (rx_byte),
    .noise_i   (rx_noise),
    .ferr_i    (rx_ferr),
    .idle_set_i(idle_set),
    .stat_rd_i (stat_rd_i),
    .data_rd_i (data_rd_i),
    .data_o    (data_o),
    .full_o    (full_o),
    .ovr_o     (ovr_o),
    .noise_o   (noise_o),
    .ferr_o    (ferr_o),
    .idle_o    (idle_o)
  );

  assign irq_o = (rx_ie_i && (full_o || ovr_o)) || (idle_ie_i && idle_o);
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 data_rd_i,
  input logic                 rx_ie_i,
  input logic                 idle_ie_i,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 full_o,
  input logic                 ovr_o,
  input logic                 noise_o,
  input logic                 idle_o,
  input logic                 irq_o
);
  a_r4_ovr_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> full_o);
  a_r4_ovr_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(data_o));
  a_r3_load_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> full_o);
  a_r5_noise_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(noise_o) |-> full_o);
  a_r8_full_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(data_rd_i));
  a_r7_idle_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> $past(data_rd_i));
  a_r9_irq_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie_i && full_o) |-> irq_o);
  a_r9_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ie_i && idle_o) |-> irq_o);
  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o || ovr_o || idle_o) |-> !irq_o);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_rd_i(data_rd_i),
  .rx_ie_i  (rx_ie_i),
  .idle_ie_i(idle_ie_i),
  .data_o   (data_o),
  .full_o   (full_o),
  .ovr_o    (ovr_o),
  .noise_o  (noise_o),
  .idle_o   (idle_o),
  .irq_o    (irq_o)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic       data_rd_i = 1'b0;
  logic       rx_ie_i = 1'b0;
  logic       idle_ie_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o, ovr_o, noise_o, ferr_o, idle_o, irq_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_data;
  logic       m_full, m_ovr, m_noise, m_ferr, m_idle;

  always #5 clk_i = ~clk_i;

  uart_rx_status u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .tick_i(tick_i),
    .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i), .rx_ie_i(rx_ie_i),
    .idle_ie_i(idle_ie_i), .data_o(data_o), .full_o(full_o), .ovr_o(ovr_o),
    .noise_o(noise_o), .ferr_o(ferr_o), .idle_o(idle_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic rie, input logic iie, input logic f,
                                   input logic o, input logic i);
    return (rie & (f | o)) | (iie & i);
  endfunction

  task automatic one_tick(input logic v);
    @(negedge clk_i);
    rxd_i  = v;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) one_tick(v);
  endtask

  // glitch: bit index 0 start, 1..8 data, 9 stop, -1 none; inverts tick 8 of that bit
  task automatic send(input logic [7:0] b, input logic stop, input int glitch);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++)
      for (int t = 0; t < 16; t++)
        one_tick((glitch == k && t == 8) ? ~fr[k] : fr[k]);
    hold(1'b1, 4);
  endtask

  function automatic void model_rx(input logic [7:0] b, input logic stop, input int glitch);
    if (m_full) m_ovr = 1'b1;
    else begin
      m_full = 1'b1; m_data = b; m_noise = (glitch >= 0); m_ferr = !stop;
    end
  endfunction

  task automatic read_seq(input logic with_stat);
    if (with_stat) begin
      @(negedge clk_i); stat_rd_i = 1'b1;
      @(negedge clk_i); stat_rd_i = 1'b0;
    end
    @(negedge clk_i); data_rd_i = 1'b1;
    @(negedge clk_i); data_rd_i = 1'b0;
    if (with_stat) begin
      m_full = 0; m_ovr = 0; m_noise = 0; m_ferr = 0; m_idle = 0;
    end
  endtask

  task automatic check_all(input string req);
    @(negedge clk_i);
    chk({req, " data"},  32'(data_o),  32'(m_data));
    chk({req, " full"},  32'(full_o),  32'(m_full));
    chk({req, " ovr"},   32'(ovr_o),   32'(m_ovr));
    chk({req, " noise"}, 32'(noise_o), 32'(m_noise));
    chk({req, " ferr"},  32'(ferr_o),  32'(m_ferr));
    chk({req, " idle"},  32'(idle_o),  32'(m_idle));
    chk("R9 irq", 32'(irq_o), 32'(exp_irq(rx_ie_i, idle_ie_i, m_full, m_ovr, m_idle)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_data = 0; m_full = 0; m_ovr = 0; m_noise = 0; m_ferr = 0; m_idle = 0;
    repeat (3) @(negedge clk_i);
    check_all("R10 reset");
    rst_ni = 1'b1;

    hold(1'b1, 200);
    check_all("R7 never busy");

    rx_ie_i = 1'b1;
    send(8'hA5, 1'b1, -1); model_rx(8'hA5, 1'b1, -1);
    check_all("R3 R2 first char");

    read_seq(1'b0);
    check_all("R8 data read alone");
    read_seq(1'b1);
    check_all("R8 clear sequence");

    hold(1'b0, 3); hold(1'b1, 40);
    check_all("R1 short low pulse");

    send(8'h3C, 1'b1, 4); model_rx(8'h3C, 1'b1, 4);
    check_all("R5 R2 noisy bit");

    send(8'h81, 1'b1, -1); model_rx(8'h81, 1'b1, -1);
    check_all("R4 overrun");

    read_seq(1'b1);
    send(8'h55, 1'b0, -1); model_rx(8'h55, 1'b0, -1);
    hold(1'b1, 8);
    check_all("R6 stop low");

    read_seq(1'b1);
    idle_ie_i = 1'b1; rx_ie_i = 1'b0;
    hold(1'b1, 170); m_idle = 1'b1;
    check_all("R7 idle after busy");
    read_seq(1'b1);
    hold(1'b1, 200);
    check_all("R7 no repeat");

    for (int n = 0; n < 30; n++) begin
      logic [7:0] b;
      logic       stp;
      int         g;
      b   = 8'($urandom);
      stp = ($urandom % 6) != 0;
      g   = (($urandom % 3) == 0) ? int'($urandom % 10) : -1;
      rx_ie_i   = 1'($urandom);
      idle_ie_i = 1'($urandom);
      send(b, stp, g); model_rx(b, stp, g);
      hold(1'b1, 4);
      check_all("R3 R4 R5 R6 random");
      if (($urandom % 3) != 0) begin
        read_seq(1'b1);
        check_all("R8 random clear");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule